// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope analogue-to-digital converter. It selects what feeds an external integrator and counts clocks. An external comparator watches the integrator. After a start strobe, the block integrates the unknown input for a fixed number of clocks. It then switches the integrator to the negative reference and counts how many clocks the integrator takes to return to zero. That second count is proportional to the input, and it is the conversion result.

The counter advances only while the comparator output is high. The fixed phase ends when the N-bit counter wraps. The wrap sets the phase flag and moves the switch to the reference. The variable phase ends when the comparator falls. If the integrator never returns to zero before a second wrap, the conversion ends with a saturated result and an overrange flag.

Top module: `dsadc_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy_o`, `done_o`, `sel_ref_o` and `ovr_o` are 0 and `result_o` is 0; reset also aborts a conversion that is in progress.
- R2: A high `start_i` seen at a clock edge while idle begins a conversion with the counter at zero and `sel_ref_o` at 0 (unknown input); `busy_o` is 1 from the next cycle until the conversion ends.
- R3: The run-up phase lasts exactly 2^CNT_W clock edges at which `cmp_i` is high. At the edge where the counter wraps from all ones to zero, `sel_ref_o` becomes 1 (negative reference).
- R4: A clock edge at which `cmp_i` is low does not advance the counter in either phase, so each such edge during run-up lengthens run-up by one cycle.
- R5: In run-down, the counter advances at each edge with `cmp_i` high. The first edge with `cmp_i` low ends the conversion, and `result_o` becomes the number of run-down edges counted (0 if `cmp_i` is already low at the first run-down edge).
- R6: At the end of a conversion, `done_o` is 1 for exactly one cycle. In that same cycle `result_o` and `ovr_o` carry the new values, `busy_o` is 0 and `sel_ref_o` is back at 0.
- R7: A `start_i` pulse during a conversion is ignored: it neither restarts nor lengthens the run-up.
- R8: If the counter would wrap a second time in run-down, the conversion ends with `result_o` all ones and `ovr_o` = 1. A conversion that ends normally clears `ovr_o`.
- R9: `result_o` and `ovr_o` keep their value between conversions whatever `cmp_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-of-conversion strobe |
| cmp_i | input | 1 | Comparator output, high while integrator output is below zero |
| sel_ref_o | output | 1 | Integrator switch: 0 = unknown input, 1 = negative reference |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| ovr_o | output | 1 | Last conversion saturated |
| result_o | output | CNT_W | Last conversion count |

## Verification
A wrong sequencer state shows at the ports within one clock. `sel_ref_o` or `busy_o` then takes the wrong level, or `done_o` pulses early. A miscounting counter shows as a run-up whose length differs from 2^CNT_W gated edges, measured edge by edge until `sel_ref_o` rises. It also shows as a result that differs from the number of run-down edges the bench allowed. A bad wrap or saturation path shows at the end of the conversion: `ovr_o` is wrong or `result_o` is not all ones.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUNUP    = 2'd1,
        ST_RUNDOWN  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic clr;      // hold counter at zero
        logic en;       // gated count enable
        logic sel;      // 1 = negative reference to integrator
        logic capture;  // end of conversion this edge
        logic ovr;      // end is due to second wrap
    } seq_ctl_t;

    function automatic logic phase_active(input seq_state_t s);
        return (s == ST_RUNUP) || (s == ST_RUNDOWN);
    endfunction

endpackage

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en)
            cnt <= cnt + 1'b1;
    end

    assign wrap = en && !clr && (cnt == CNT_MAX);

    AST_CNT_GATED: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt)); // R4

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R2

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
    import dsadc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       cmp_i,
    input  logic       wrap,
    output seq_ctl_t   ctl,
    output logic       busy
);
    seq_state_t state, state_nx;

    always_comb begin
        state_nx    = state;
        ctl         = '0;
        ctl.en      = phase_active(state) && cmp_i;
        ctl.clr     = (state == ST_IDLE);
        ctl.sel     = (state == ST_RUNDOWN);
        unique case (state)
            ST_IDLE: begin
                if (start_i) state_nx = ST_RUNUP;
            end
            ST_RUNUP: begin
                if (wrap) state_nx = ST_RUNDOWN;
            end
            ST_RUNDOWN: begin
                if (!cmp_i) begin
                    ctl.capture = 1'b1;
                    state_nx    = ST_IDLE;
                end else if (wrap) begin
                    ctl.capture = 1'b1;
                    ctl.ovr     = 1'b1;
                    state_nx    = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign busy = (state != ST_IDLE);

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUNUP && start_i && !wrap) |=> (state == ST_RUNUP)); // R7

    AST_PHASE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUNUP && wrap) |=> ctl.sel); // R3

    AST_IDLE_SEL: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ctl.sel); // R6

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         ovr_in,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] result,
    output logic         ovr,
    output logic         done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            ovr    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= capture;
            if (capture) begin
                result <= ovr_in ? {W{1'b1}} : cnt;
                ovr    <= ovr_in;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_OVR_ALLONES: assert property (@(posedge clk) disable iff (rst)
        ovr |-> (result == {W{1'b1}})); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(result) && $stable(ovr))); // R9

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
    import dsadc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             sel_ref_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             ovr_o,
    output logic [CNT_W-1:0] result_o
);
    seq_ctl_t         ctl;
    logic [CNT_W-1:0] cnt;
    logic             wrap;

    dsadc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cmp_i   (cmp_i),
        .wrap    (wrap),
        .ctl     (ctl),
        .busy    (busy_o)
    );

    dsadc_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.clr),
        .en   (ctl.en),
        .cnt  (cnt),
        .wrap (wrap)
    );

    dsadc_result #(.W(CNT_W)) u_res (
        .clk     (clk),
        .rst     (rst),
        .capture (ctl.capture),
        .ovr_in  (ctl.ovr),
        .cnt     (cnt),
        .result  (result_o),
        .ovr     (ovr_o),
        .done    (done_o)
    );

    assign sel_ref_o = ctl.sel;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!busy_o && !sel_ref_o && !done_o && result_o == '0)); // R1

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !sel_ref_o)); // R6

endmodule

// File: tb/dsadc_ctrl_tb_top.sv
module dsadc_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int RUNUP_LEN  = 1 << N;
    localparam int NV         = 6;

    localparam int K_VEC   [NV] = '{0, 1, 37, 128, 255, 256};
    localparam int EXP_RES [NV] = '{0, 1, 37, 128, 255, 255};
    localparam int EXP_OVR [NV] = '{0, 0, 0,  0,   0,   1};
    localparam int GDROP   [NV] = '{0, 3, 0,  7,   0,   1};
    localparam int MIDST   [NV] = '{0, 0, 1,  0,   1,   0};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         cmp_i = 1'b1;
    logic         sel_ref_o, busy_o, done_o, ovr_o;
    logic [N-1:0] result_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsadc_ctrl #(.CNT_W(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cmp_i     (cmp_i),
        .sel_ref_o (sel_ref_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .ovr_o     (ovr_o),
        .result_o  (result_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_conv(input int k, input int gdrop, input int midst,
                            input int exp_res, input int exp_ovr);
        int n;
        int j;
        @(negedge clk); start_i = 1'b1; cmp_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check("R2 busy after start", busy_o, 1);
        check("R2 select at input during run-up", sel_ref_o, 0);
        n = 0;
        while (!sel_ref_o) begin
            cmp_i   = (n < gdrop) ? 1'b0 : 1'b1;
            start_i = (midst != 0 && n == 5) ? 1'b1 : 1'b0;
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        cmp_i   = 1'b1;
        check("R3 R4 R7 run-up length", n, RUNUP_LEN + gdrop);
        j = 0;
        while (j < k && !done_o) begin
            @(negedge clk);
            j++;
        end
        if (!done_o) begin
            cmp_i = 1'b0;
            @(negedge clk);
        end
        check("R6 done at end", done_o, 1);
        check("R5 result", result_o, exp_res);
        check("R8 overrange flag", ovr_o, exp_ovr);
        check("R6 select back to input", sel_ref_o, 0);
        check("R6 idle at end", busy_o, 0);
        @(negedge clk);
        check("R6 done one cycle", done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy_o, 0);
        check("R1 select in reset", sel_ref_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 result after reset", result_o, 0);
        check("R1 done after reset", done_o, 0);
        check("R1 ovr after reset", ovr_o, 0);

        for (int v = 0; v < NV; v++)
            run_conv(K_VEC[v], GDROP[v], MIDST[v], EXP_RES[v], EXP_OVR[v]);

        // R8: normal conversion after overrange clears the flag
        run_conv(20, 0, 0, 20, 0);

        // R9: result holds while idle with comparator toggling
        for (int i = 0; i < 12; i++) begin
            cmp_i = i[0];
            @(negedge clk);
        end
        check("R9 result held", result_o, 20);
        check("R9 ovr held", ovr_o, 0);
        check("R9 stays idle", busy_o, 0);

        // R1: reset mid run-down aborts and clears
        @(negedge clk); start_i = 1'b1; cmp_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (!sel_ref_o) @(negedge clk);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 abort busy", busy_o, 0);
        check("R1 abort select", sel_ref_o, 0);
        check("R1 abort result", result_o, 0);
        check("R1 abort done", done_o, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule